// File: doc/BRIEF.md
# Serial Character Receiver with Status Flags

This block receives asynchronous serial characters on a single line and hands each one to a processor through a small register bus. The incoming line first passes through a two-flop synchronizer. It is then sampled at sixteen times the bit rate, with the rate set by an external baud tick. A start edge is confirmed at the middle of the start bit, and every later bit is taken at its centre. The bits are assembled in a shift register, and a clean character moves into a holding register that the host reads.

The status byte gives the host five flags. Four of them report the most recent transfer: a character is waiting, a character was lost, a parity mismatch, and a low stop bit. The fifth is a hunt flag that software raises to skip the rest of a character already on the line. While the hunt flag is set, received characters leave the holding register and the four transfer flags untouched. The flag drops by itself once the line has stayed high for ten whole bit periods. The control register holds two enables, one for the receiver and one for parity.

Top module: `rx_status_unit`

## Requirements
- R1: After reset, `rxData` reads 0x00, `rxStatus` reads 0x00, and the receiver and parity enables are both off.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, an even-parity bit only when parity is enabled, and one stop bit. A clean frame loads the holding register and sets status bit 0 (ready). The `rxStatus` layout is bit 0 ready, bit 1 lost, bit 2 parity error, bit 3 framing error, bit 4 hunt.
- R3: A control write sets the receiver enable from `busWdata[0]` and the parity enable from `busWdata[1]`. While the receiver is disabled, line activity changes neither `rxData` nor `rxStatus`.
- R4: A `dataRdEn` pulse clears status bits 0 to 3. If a transfer happens in the same cycle, the clear is applied first and the transfer second.
- R5: If a clean character finishes while ready is set, status bit 1 (lost) is set. The earlier character stays in `rxData` and the new one is dropped.
- R6: With parity enabled, a frame whose data and parity bits hold an odd number of ones sets status bit 2. It does not set ready and does not load `rxData`.
- R7: A frame sampled low at the stop-bit centre sets status bit 3. It does not set ready and does not load `rxData`.
- R8: A status write with `busWdata[4]=1` sets the hunt flag. A status write with `busWdata[4]=0` has no effect, and status writes never change bits 0 to 3. While the hunt flag is set, completed frames change neither `rxData` nor bits 0 to 3.
- R9: The hunt flag clears after ten consecutive bit periods (160 baud ticks) of high line samples. Any low sample restarts that count.
- R10: Status bits 5 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxdIn | input | 1 | Asynchronous serial line, idle high |
| baudTick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| dataRdEn | input | 1 | Host read of the holding register (clears flags) |
| statusWrEn | input | 1 | Host write of the status register |
| ctrlWrEn | input | 1 | Host write of the control register |
| busWdata | input | 8 | Write data for status and control writes |
| rxData | output | 8 | Holding register contents |
| rxStatus | output | 8 | Status byte |

## Verification
Assertions inside the modules check the following on every cycle:
- A read clears the four transfer flags.
- A lost character leaves the holding register unchanged.
- An errored frame never raises ready.
- The hunt flag freezes the data and the transfer flags.
- The hunt flag only drops after a high line sample.
- Disabling the receiver returns the bit-timing state machine to idle.
- A false start is rejected.

Only the bench's frames can show the rest:
- The bit order on the line is decoded correctly.
- The parity bit appears only when parity is enabled.
- The parity check itself is correct.
- A disabled receiver ignores the line.
- The ten-bit-period hunt timeout restarts when the line goes low.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rxState_t;

  // Strobes from bit-timing control to the datapath
  typedef struct packed {
    logic tick;      // baud tick passed through
    logic lineHigh;  // synchronized line level
    logic shiftEn;   // capture one data bit
    logic bitVal;    // value of the captured bit
    logic done;      // stop bit sampled, frame complete
    logic parErr;    // parity mismatch on this frame
    logic frmErr;    // stop bit was low
  } rxStrobe_t;

endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxdIn,
  input  logic baudTick,
  input  logic rxEn,
  input  logic parEn,
  output rxs_pkg::rxStrobe_t strb
);
  import rxs_pkg::*;

  localparam int OSW = $clog2(OVERSAMPLE);
  localparam int BIW = $clog2(DATA_BITS);
  localparam logic [OSW-1:0] HALF_LAST = OSW'(OVERSAMPLE / 2 - 1);
  localparam logic [OSW-1:0] FULL_LAST = OSW'(OVERSAMPLE - 1);
  localparam logic [BIW-1:0] BIT_LAST  = BIW'(DATA_BITS - 1);

  logic rxMeta, rxSync;
  rxState_t state;
  logic [OSW-1:0] tickCnt;
  logic [BIW-1:0] bitIdx;
  logic parAcc, hadPar;
  logic sampleNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxdIn;
      rxSync <= rxMeta;
    end
  end

  assign sampleNow = baudTick && (tickCnt == FULL_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !rxEn) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      parAcc  <= 1'b0;
      hadPar  <= 1'b0;
    end else if (baudTick) begin
      case (state)
        S_IDLE: if (!rxSync) begin
          state   <= S_START;
          tickCnt <= '0;
        end
        S_START: begin
          if (tickCnt == HALF_LAST) begin
            tickCnt <= '0;
            if (rxSync) begin
              state <= S_IDLE;
            end else begin
              state  <= S_DATA;
              bitIdx <= '0;
              parAcc <= 1'b0;
              hadPar <= 1'b0;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        S_DATA: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_LAST) begin
            parAcc <= parAcc ^ rxSync;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == BIT_LAST) begin
              state  <= parEn ? S_PAR : S_STOP;
              hadPar <= parEn;
            end
          end
        end
        S_PAR: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_LAST) begin
            parAcc <= parAcc ^ rxSync;
            state  <= S_STOP;
          end
        end
        S_STOP: begin
          tickCnt <= tickCnt + 1'b1;
          if (tickCnt == FULL_LAST) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.tick     = baudTick;
    strb.lineHigh = rxSync;
    strb.bitVal   = rxSync;
    strb.shiftEn  = (state == S_DATA) && sampleNow;
    strb.done     = (state == S_STOP) && sampleNow;
    strb.parErr   = hadPar && parAcc;
    strb.frmErr   = !rxSync;
  end

  // R3: disabling the receiver returns the timing machine to idle
  p_disable_idles_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> state == S_IDLE);

  // R2: a start that is high again at its centre is rejected
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxEn && baudTick && state == S_START && tickCnt == HALF_LAST && rxSync
    |=> state == S_IDLE);

endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int IDLE_BITS  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  rxs_pkg::rxStrobe_t strb,
  input  logic dataRdEn,
  input  logic statusWrEn,
  input  logic ctrlWrEn,
  input  logic [7:0] busWdata,
  output logic rxEn,
  output logic parEn,
  output logic [DATA_BITS-1:0] rxData,
  output logic [7:0] rxStatus
);
  localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE;
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_TICKS - 1);

  logic [1:0] cfgReg;
  logic [DATA_BITS-1:0] shiftReg, dataReg, dataNxt;
  logic full, ovr, prty, frme, huntFlag;
  logic fullNxt, ovrNxt, prtyNxt, frmeNxt;
  logic [CW-1:0] idleCnt;
  logic unusedBits;

  assign unusedBits = ^{busWdata[7:5], busWdata[3:2]};
  assign rxEn  = cfgReg[0];
  assign parEn = cfgReg[1];

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= 2'b00;
    else if (ctrlWrEn) cfgReg <= busWdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {strb.bitVal, shiftReg[DATA_BITS-1:1]};
  end

  // Read clear first, then any transfer of the finished frame
  always_comb begin
    fullNxt = full;
    ovrNxt  = ovr;
    prtyNxt = prty;
    frmeNxt = frme;
    dataNxt = dataReg;
    if (dataRdEn) begin
      fullNxt = 1'b0;
      ovrNxt  = 1'b0;
      prtyNxt = 1'b0;
      frmeNxt = 1'b0;
    end
    if (strb.done && !huntFlag) begin
      if (strb.parErr || strb.frmErr) begin
        prtyNxt = prtyNxt | strb.parErr;
        frmeNxt = frmeNxt | strb.frmErr;
      end else if (fullNxt) begin
        ovrNxt = 1'b1;
      end else begin
        dataNxt = shiftReg;
        fullNxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      full    <= 1'b0;
      ovr     <= 1'b0;
      prty    <= 1'b0;
      frme    <= 1'b0;
      dataReg <= '0;
    end else begin
      full    <= fullNxt;
      ovr     <= ovrNxt;
      prty    <= prtyNxt;
      frme    <= frmeNxt;
      dataReg <= dataNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      huntFlag <= 1'b0;
      idleCnt  <= '0;
    end else if (statusWrEn && busWdata[4]) begin
      huntFlag <= 1'b1;
      idleCnt  <= '0;
    end else if (huntFlag && strb.tick) begin
      if (!strb.lineHigh) begin
        idleCnt <= '0;
      end else if (idleCnt == IDLE_LAST) begin
        huntFlag <= 1'b0;
        idleCnt  <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  assign rxData   = dataReg;
  assign rxStatus = {3'b000, 1'b0, huntFlag, frme, prty, ovr, full};

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataRdEn && !(strb.done && !huntFlag) |=> rxStatus[3:0] == 4'b0000);

  p_lost_keeps_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    full && !dataRdEn && strb.done && !huntFlag && !strb.parErr && !strb.frmErr
    |=> ovr && $stable(dataReg));

  p_error_no_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    !full && strb.done && (strb.parErr || strb.frmErr)
    |=> !full);

  p_hunt_freezes_r8: assert property (@(posedge clk) disable iff (!rstN)
    huntFlag && !dataRdEn |=> $stable(rxStatus[3:0]) && $stable(dataReg));

  p_hunt_clear_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(huntFlag) |-> $past(strb.lineHigh));

endmodule

// File: rtl/rx_status_unit.sv
module rx_status_unit #(
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxdIn,
  input  logic       baudTick,
  input  logic       dataRdEn,
  input  logic       statusWrEn,
  input  logic       ctrlWrEn,
  input  logic [7:0] busWdata,
  output logic [7:0] rxData,
  output logic [7:0] rxStatus
);
  rxs_pkg::rxStrobe_t strb;
  logic rxEn, parEn;

  rxs_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxdIn(rxdIn), .baudTick(baudTick),
    .rxEn(rxEn), .parEn(parEn), .strb(strb)
  );

  rxs_datapath #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(8), .IDLE_BITS(IDLE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataRdEn(dataRdEn),
    .statusWrEn(statusWrEn), .ctrlWrEn(ctrlWrEn), .busWdata(busWdata),
    .rxEn(rxEn), .parEn(parEn), .rxData(rxData), .rxStatus(rxStatus)
  );

endmodule

// File: tb/sim_rx_status_unit.sv
`timescale 1ns/1ps
module sim_rx_status_unit;
  localparam int BITCYC = 32;  // 16 ticks, one tick every 2 cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxd = 1'b1;
  logic baudTick = 1'b0;
  logic dataRdEn = 1'b0, statusWrEn = 1'b0, ctrlWrEn = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] rxData, rxStatus;

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  logic [7:0] expData = 8'h00;
  bit expFull = 0, expOvr = 0, expPrty = 0, expFrme = 0, expHunt = 0;
  bit curPar = 0, curEn = 0;

  rx_status_unit u0 (
    .clk(clk), .rstN(rstN), .rxdIn(rxd), .baudTick(baudTick),
    .dataRdEn(dataRdEn), .statusWrEn(statusWrEn), .ctrlWrEn(ctrlWrEn),
    .busWdata(busWdata), .rxData(rxData), .rxStatus(rxStatus)
  );

  always #2 clk = ~clk;

  always @(posedge clk) baudTick <= rstN ? ~baudTick : 1'b0;

  function automatic logic [7:0] expStatus();
    return {3'b000, 1'b0, expHunt, expFrme, expPrty, expOvr, expFull};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input bit en, input bit par);
    @(negedge clk);
    busWdata = {6'b0, par, en};
    ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    curEn = en;
    curPar = par;
  endtask

  task automatic wrStatus(input logic [7:0] v);
    @(negedge clk);
    busWdata = v;
    statusWrEn = 1'b1;
    @(negedge clk);
    statusWrEn = 1'b0;
    if (v[4]) expHunt = 1;
  endtask

  task automatic readData(input string req);
    @(negedge clk);
    chk(req, rxData, expData);
    dataRdEn = 1'b1;
    @(negedge clk);
    dataRdEn = 1'b0;
    expFull = 0; expOvr = 0; expPrty = 0; expFrme = 0;
    chk(req, rxStatus, expStatus());
  endtask

  task automatic lineFor(input bit v, input int cyc);
    rxd = v;
    repeat (cyc) @(negedge clk);
  endtask

  // Drives one frame and updates the model of the expected state
  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit badStop);
    bit pe, fe;
    @(negedge clk);
    lineFor(1'b0, BITCYC);
    for (int i = 0; i < 8; i++) lineFor(d[i], BITCYC);
    if (curPar) lineFor((^d) ^ badPar, BITCYC);
    if (badStop) begin
      lineFor(1'b0, 24);
      lineFor(1'b1, BITCYC - 24);
    end else begin
      lineFor(1'b1, BITCYC);
    end
    lineFor(1'b1, 2 * BITCYC);
    pe = curPar && badPar;
    fe = badStop;
    if (curEn && !expHunt) begin
      if (pe || fe) begin
        expPrty |= pe;
        expFrme |= fe;
      end else if (expFull) begin
        expOvr = 1;
      end else begin
        expData = d;
        expFull = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", rxStatus, 8'h00);
    chk("R1 data", rxData, 8'h00);

    // R3 disabled receiver ignores the line
    sendFrame(8'h5A, 0, 0);
    chk("R3 disabled status", rxStatus, 8'h00);
    chk("R3 disabled data", rxData, 8'h00);

    // R2 clean frames, LSB first, no parity
    wrCtrl(1, 0);
    sendFrame(8'h01, 0, 0);
    chk("R2 ready", rxStatus, expStatus());
    readData("R4 read 01");
    sendFrame(8'h80, 0, 0);
    chk("R2 msb", rxData, 8'h80);
    readData("R4 read 80");

    // R5 lost character
    sendFrame(8'h3C, 0, 0);
    sendFrame(8'hC3, 0, 0);
    chk("R5 lost flag", rxStatus, 8'h03);
    chk("R5 first kept", rxData, 8'h3C);
    readData("R4 after lost");

    // R6 parity
    wrCtrl(1, 1);
    sendFrame(8'hA5, 0, 0);
    chk("R6 parity good", rxStatus, expStatus());
    readData("R6 read good");
    sendFrame(8'h17, 1, 0);
    chk("R6 parity bad", rxStatus, 8'h04);
    chk("R6 data kept", rxData, 8'hA5);
    readData("R6 read bad");

    // R7 framing
    wrCtrl(1, 0);
    sendFrame(8'h66, 0, 1);
    chk("R7 framing", rxStatus, 8'h08);
    readData("R7 read");

    // R8 hunt write, write of zero ignored, bits 0-3 not writable
    wrStatus(8'h0F);
    chk("R8 flags not writable", rxStatus, 8'h00);
    wrStatus(8'h10);
    chk("R8 hunt set", rxStatus, 8'h10);
    wrStatus(8'h00);
    chk("R8 zero write ignored", rxStatus, 8'h10);
    sendFrame(8'h42, 0, 0);
    chk("R8 frozen status", rxStatus, 8'h10);
    chk("R8 frozen data", rxData, expData);
    // R9 timeout counted from the last low (bit 7 of 0x42 is low)
    repeat (160) @(negedge clk);
    chk("R9 still hunting", rxStatus[4], 1'b1);
    repeat (100) @(negedge clk);
    expHunt = 0;
    chk("R9 hunt cleared", rxStatus[4], 1'b0);

    // R9 low sample restarts the count
    wrStatus(8'h10);
    repeat (250) @(negedge clk);
    lineFor(1'b0, 4);
    lineFor(1'b1, 250);
    chk("R9 restarted", rxStatus[4], 1'b1);
    repeat (120) @(negedge clk);
    expHunt = 0;
    chk("R9 cleared after restart", rxStatus[4], 1'b0);

    // Random frames
    for (int it = 0; it < 40; it++) begin
      logic [7:0] d;
      int kind;
      d = 8'($urandom);
      kind = $urandom % 8;
      if (($urandom % 4) == 0) wrCtrl(1, ($urandom % 2) == 1);
      if (($urandom % 2) == 0) readData("R4 random read");
      sendFrame(d, kind == 5, kind == 6);
      chk("R2 random status", rxStatus, expStatus());
      chk("R2 random data", rxData, expData);
      chk("R10 high bits", rxStatus[7:5], 3'b000);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule